// File: doc/BRIEF.md
# Quadrature Position Counter

This block keeps a 32-bit position count for a rotary or linear encoder. It watches the two encoder channels A and B, which arrive already synchronised to the block clock. It turns their transitions into count steps by one of four decoding schemes. The three quadrature schemes count one, two or four steps per encoder cycle. A two-pulse scheme treats A as an up pulse line and B as a down pulse line.

An optional index line Z reloads the count with a programmed value. The reload fires only when Z is high and the encoder sits in one selected phase of its four-state cycle. This lets the reference position be set to a fixed point within the encoder cycle.

The count moves only while the arm input is high. In the quadrature schemes, a jump across two states in one sample is treated as an error: it leaves the count unchanged and latches an error flag.

Top module: `enc_pos_counter`

## Requirements
- R1: Reset clears the count to 0 and the error flag to 0. The first clock after reset only captures the {A,B} state, so a non-zero state present at reset release causes no count step and no error.
- R2: With mode_i = 0 (X1), the step from {A,B} = 00 to 10 (A leads B) adds one, and the step from 10 to 00 (B leads A) subtracts one. No other transition moves the count.
- R3: With mode_i = 1 (X2), each edge of A counts. An A edge that moves along the sequence 00, 10, 11, 01 adds one, and an A edge that moves against it subtracts one. Edges of B do not count.
- R4: With mode_i = 2 (X4), every single-bit change of {A,B} counts. A move forward along 00, 10, 11, 01, 00 adds one, and a move backward subtracts one.
- R5: In the quadrature modes (0 to 2), a change of both A and B in one sample leaves the count unchanged. If the counter is armed, that change also sets err_o, which stays high until reset.
- R6: With mode_i = 3 (two-pulse), a rising edge of A alone adds one and a rising edge of B alone subtracts one. Rising edges of both in the same cycle leave the count unchanged. Falling edges never count, and no transition sets err_o.
- R7: In the quadrature modes, when the counter is armed, z_i is high and the current {A,B} equals reload_phase_i, the count becomes reload_val_i on the next clock. This reload takes priority over any step in the same cycle. In two-pulse mode, z_i is ignored.
- R8: While arm_i is low, the count holds, and neither reloads nor illegal jumps have any effect.
- R9: The count wraps modulo 2^32: one step down from 0 gives 0xFFFFFFFF, and one step up from 0xFFFFFFFF gives 0.
- R10: A step or reload seen in the sampled inputs appears on count_o after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Count enable |
| mode_i | input | 2 | 0 X1, 1 X2, 2 X4, 3 two-pulse |
| a_i | input | 1 | Encoder channel A (synchronised) |
| b_i | input | 1 | Encoder channel B (synchronised) |
| z_i | input | 1 | Index channel |
| reload_val_i | input | 32 | Value loaded on index |
| reload_phase_i | input | 2 | {A,B} state in which the index reloads |
| count_o | output | 32 | Position count |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
Every count step, reload and error-flag change is due exactly one rising edge after the {A,B,Z} sample that causes it, because the previous state register and the count register are the only stages involved. The bench changes its inputs on the falling edge and samples count_o and err_o one nanosecond after the following rising edge. In that way each check sees the result of exactly one new sample. The priming cycle after reset is consumed by the restart task before any check is made.

// File: rtl/enc_cnt_pkg.sv
`timescale 1ns/1ps
package enc_cnt_pkg;
  typedef enum logic [1:0] {
    MODE_X1        = 2'd0,
    MODE_X2        = 2'd1,
    MODE_X4        = 2'd2,
    MODE_TWO_PULSE = 2'd3
  } enc_mode_e;

  typedef struct packed {
    logic inc;
    logic dec;
    logic bad;
  } enc_step_t;

  // position of an {A,B} state along the forward sequence 00,10,11,01
  function automatic logic [1:0] fwd_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   fwd_pos = 2'd0;
      2'b10:   fwd_pos = 2'd1;
      2'b11:   fwd_pos = 2'd2;
      default: fwd_pos = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/enc_input_track.sv
`timescale 1ns/1ps
module enc_input_track #(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] cur_i,
  output logic [CH_W-1:0] prev_o,
  output logic            valid_o
);
  logic [CH_W-1:0] prev_q;
  logic            primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= cur_i;
      primed_q <= 1'b1;
    end
  end

  assign prev_o  = prev_q;
  assign valid_o = primed_q;

  // R1
  primed_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/enc_step_decode.sv
`timescale 1ns/1ps
module enc_step_decode
  import enc_cnt_pkg::*;
(
  input  enc_mode_e   mode_i,
  input  logic [1:0]  prev_i,
  input  logic [1:0]  cur_i,
  output enc_step_t   step_o
);
  logic [1:0] delta;
  logic       a_edge, a_rise, b_rise;
  logic       fwd, bwd, jump;

  always_comb begin
    delta  = fwd_pos(cur_i) - fwd_pos(prev_i);
    fwd    = (delta == 2'd1);
    bwd    = (delta == 2'd3);
    jump   = (delta == 2'd2);
    a_edge = prev_i[1] ^ cur_i[1];
    a_rise = ~prev_i[1] & cur_i[1];
    b_rise = ~prev_i[0] & cur_i[0];
    step_o = '0;
    unique case (mode_i)
      MODE_X1: begin
        // only the A edges taken with B low
        step_o.inc = a_edge & fwd & ~cur_i[0];
        step_o.dec = a_edge & bwd & ~cur_i[0];
        step_o.bad = jump;
      end
      MODE_X2: begin
        step_o.inc = a_edge & fwd;
        step_o.dec = a_edge & bwd;
        step_o.bad = jump;
      end
      MODE_X4: begin
        step_o.inc = fwd;
        step_o.dec = bwd;
        step_o.bad = jump;
      end
      default: begin
        step_o.inc = a_rise & ~b_rise;
        step_o.dec = b_rise & ~a_rise;
      end
    endcase
  end
endmodule

// File: rtl/enc_index_match.sv
`timescale 1ns/1ps
module enc_index_match
  import enc_cnt_pkg::*;
#(
  parameter int unsigned PH_W = 2
) (
  input  enc_mode_e       mode_i,
  input  logic            z_i,
  input  logic [PH_W-1:0] cur_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            hit_o
);
  assign hit_o = z_i && (cur_i == phase_i) && (mode_i != MODE_TWO_PULSE);
endmodule

// File: rtl/enc_pos_counter.sv
`timescale 1ns/1ps
module enc_pos_counter
  import enc_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [1:0]       mode_i,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             z_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [1:0]       reload_phase_i,
  output logic [CNT_W-1:0] count_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  enc_mode_e        mode;
  logic [1:0]       cur_ab, prev_ab;
  logic             valid, hit;
  enc_step_t        step;
  logic [CNT_W-1:0] count_q;
  logic             err_q;

  assign mode   = enc_mode_e'(mode_i);
  assign cur_ab = {a_i, b_i};

  enc_input_track #(.CH_W(2)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur_ab),
    .prev_o (prev_ab),
    .valid_o(valid)
  );

  enc_step_decode u_decode (
    .mode_i(mode),
    .prev_i(prev_ab),
    .cur_i (cur_ab),
    .step_o(step)
  );

  enc_index_match #(.PH_W(2)) u_index (
    .mode_i (mode),
    .z_i    (z_i),
    .cur_i  (cur_ab),
    .phase_i(reload_phase_i),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      err_q   <= 1'b0;
    end else if (arm_i) begin
      if (hit)                    count_q <= reload_val_i;
      else if (valid && step.inc) count_q <= count_q + 1'b1;
      else if (valid && step.dec) count_q <= count_q - 1'b1;
      if (valid && step.bad)      err_q   <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign err_o   = err_q;

  // R4
  step_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step.inc && step.dec));
  // R5
  bad_no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && valid && step.bad && !hit) |=> $stable(count_o));
  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R6
  tp_both_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !hit && valid && mode == MODE_TWO_PULSE && prev_ab == 2'b00 && cur_ab == 2'b11)
      |=> $stable(count_o));
  // R7
  reload_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && hit) |=> count_o == $past(reload_val_i));
  // R8
  hold_disarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> ($stable(count_o) && $stable(err_o)));
  // R9
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && valid && !hit && step.inc && count_o == CNT_MAX) |=> count_o == '0);
  // R10
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && valid && !hit && step.inc) |=> count_o == $past(count_o) + 1'b1);
endmodule

// File: tb/enc_pos_counter_tb.sv
`timescale 1ns/1ps
module enc_pos_counter_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic        a = 1'b0, b = 1'b0, z = 1'b0;
  logic [1:0]  mode = 2'd0, phase = 2'd0;
  logic [31:0] rval = '0;
  logic [31:0] count;
  logic        err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  enc_pos_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .mode_i(mode),
    .a_i(a), .b_i(b), .z_i(z), .reload_val_i(rval),
    .reload_phase_i(phase), .count_o(count), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] ab, input logic zz = 1'b0);
    @(negedge clk);
    {a, b} = ab;
    z = zz;
    @(posedge clk);
    #1;
  endtask

  task automatic restart(input logic [1:0] m, input logic [1:0] ab0);
    @(negedge clk);
    rst_n = 1'b0; mode = m; {a, b} = ab0; z = 1'b0; arm = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic up_cycle();
    step(2'b10); step(2'b11); step(2'b01); step(2'b00);
  endtask

  task automatic down_cycle();
    step(2'b01); step(2'b11); step(2'b10); step(2'b00);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 count in reset", count, 32'd0);
    chk("R1 err in reset", {31'd0, err}, 32'd0);
    restart(2'd2, 2'b11);
    chk("R1 prime no step", count, 32'd0);
    chk("R1 prime no err", {31'd0, err}, 32'd0);
    step(2'b01);
    chk("R1 first real step", count, 32'd1);
  endtask

  task automatic t_x1();
    restart(2'd0, 2'b00);
    step(2'b10);
    chk("R2 x1 rise A up", count, 32'd1);
    step(2'b11); step(2'b01); step(2'b00);
    chk("R2 x1 rest of cycle", count, 32'd1);
    up_cycle();
    chk("R2 x1 second cycle", count, 32'd2);
    step(2'b01); step(2'b11); step(2'b10);
    chk("R2 x1 down no move yet", count, 32'd2);
    step(2'b00);
    chk("R2 x1 fall A down", count, 32'd1);
  endtask

  task automatic t_x2();
    restart(2'd1, 2'b00);
    step(2'b10); chk("R3 x2 A rise", count, 32'd1);
    step(2'b11); chk("R3 x2 B edge ignored", count, 32'd1);
    step(2'b01); chk("R3 x2 A fall", count, 32'd2);
    step(2'b00); step(2'b01);
    chk("R3 x2 B edges ignored", count, 32'd2);
    step(2'b11); step(2'b10); step(2'b00);
    chk("R3 x2 down cycle", count, 32'd0);
  endtask

  task automatic t_x4();
    restart(2'd2, 2'b00);
    up_cycle();
    chk("R4 x4 up cycle", count, 32'd4);
    down_cycle();
    chk("R4 x4 down cycle", count, 32'd0);
    step(2'b10); step(2'b11); step(2'b10);
    chk("R4 x4 reversal", count, 32'd1);
  endtask

  task automatic t_err();
    restart(2'd2, 2'b00);
    step(2'b11);
    chk("R5 jump no move", count, 32'd0);
    chk("R5 jump sets err", {31'd0, err}, 32'd1);
    step(2'b01);
    chk("R5 counts after jump", count, 32'd1);
    step(2'b10);
    chk("R5 second jump no move", count, 32'd1);
    step(2'b00);
    chk("R5 err sticky", {31'd0, err}, 32'd1);
  endtask

  task automatic t_two_pulse();
    rval = 32'd55; phase = 2'b11;
    restart(2'd3, 2'b00);
    step(2'b10); chk("R6 rise A up", count, 32'd1);
    step(2'b00); chk("R6 fall A none", count, 32'd1);
    step(2'b01); chk("R6 rise B down", count, 32'd0);
    step(2'b00);
    step(2'b11, 1'b1);
    chk("R6 both rise none R7 z ignored", count, 32'd0);
    chk("R6 no err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_index();
    rval = 32'h1234_5678; phase = 2'b11;
    restart(2'd2, 2'b00);
    step(2'b10); chk("R7 pre step", count, 32'd1);
    step(2'b11, 1'b1); chk("R7 reload at phase", count, 32'h1234_5678);
    step(2'b01); chk("R7 step after reload", count, 32'h1234_5679);
    step(2'b00, 1'b1); chk("R7 wrong phase steps", count, 32'h1234_567A);
    rval = 32'h0000_0ABC;
    step(2'b11, 1'b1); chk("R7 reload beats jump", count, 32'h0000_0ABC);
  endtask

  task automatic t_arm();
    rval = 32'd9; phase = 2'b11;
    restart(2'd2, 2'b00);
    @(negedge clk); arm = 1'b0;
    up_cycle();
    chk("R8 disarmed hold", count, 32'd0);
    step(2'b11, 1'b1);
    chk("R8 disarmed no reload", count, 32'd0);
    chk("R8 disarmed jump no err", {31'd0, err}, 32'd0);
    @(negedge clk); arm = 1'b1; z = 1'b0;
    step(2'b01);
    chk("R8 rearmed counts", count, 32'd1);
  endtask

  task automatic t_wrap();
    restart(2'd2, 2'b00);
    step(2'b01); chk("R9 wrap down", count, 32'hFFFF_FFFF);
    step(2'b00); chk("R9 wrap up", count, 32'd0);
    rval = 32'hFFFF_FFFF; phase = 2'b10;
    step(2'b10, 1'b1); chk("R9 load max", count, 32'hFFFF_FFFF);
    step(2'b11); chk("R9 max plus one", count, 32'd0);
  endtask

  initial begin
    t_reset();
    t_x1();
    t_x2();
    t_x4();
    t_err();
    t_two_pulse();
    t_index();
    t_arm();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule